// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor bus interface and watches the three-bit status code the processor presents each clock. When the code leaves the all-ones idle value, a bus cycle has begun. When the code returns to all ones, the cycle is over. From these two events the block produces a one-clock start pulse, a one-clock end pulse and a busy flag. For the active part of each cycle it also drives one-hot command strobes: memory read, memory write, I/O read, I/O write, code fetch and interrupt acknowledge. A separate halt indication covers the halt code.

The code is captured in the clock where the cycle begins. The strobe follows that captured code until the cycle ends, so a status that wanders between active codes in mid-cycle cannot switch commands. While the bus is floated for a hold, the status lines carry nothing meaningful. A float indication therefore forces the decoder to read the status as idle. All outputs are registered.

Top module: `bus_status_decoder`

## Requirements
- R1: While rst_ni is low, cyc_start_o, cyc_end_o, busy_o, halt_o and every bit of cmd_o are 0, including when reset arrives in the middle of a cycle.
- R2: After a clock edge that samples a non-idle code (anything but 3'b111) while the previous sampled code was 3'b111, cyc_start_o is 1 for exactly that one clock.
- R3: busy_o rises together with cyc_start_o and stays 1 until the clock edge that samples 3'b111.
- R4: The edge that samples 3'b111 while busy_o is 1 sets cyc_end_o for one clock and clears busy_o in the same edge.
- R5: Code mapping 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 100 code fetch, 101 memory read, 110 memory write selects cmd_o bit 0, 1, 2, 3, 4, 5 respectively. The bit is 1 from the edge after the start edge until the end edge, and cmd_o is zero while busy_o is 0.
- R6: Code 011 (halt) sets halt_o over the same window instead of any cmd_o bit.
- R7: While float_i is 1 the status is read as 3'b111: non-idle codes start no cycle, and raising float_i during a cycle ends it.
- R8: A status of all ones in the first clocks after reset starts no cycle.
- R9: A change from one non-idle code to another without passing through 3'b111 gives no new start pulse and leaves the strobe on the code captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| status_i | input | 3 | Processor bus status code, 3'b111 idle |
| float_i | input | 1 | Bus floated for hold; status is not valid |
| cyc_start_o | output | 1 | One-clock pulse at the start of a bus cycle |
| cyc_end_o | output | 1 | One-clock pulse at the end of a bus cycle |
| busy_o | output | 1 | A bus cycle is in progress |
| cmd_o | output | 6 | One-hot command strobes, bit order as in R5 |
| halt_o | output | 1 | Halt cycle in progress |

## Verification
Two situations are hard to reach from the ports. The first is a cycle cut short by the float indication rather than by an idle code. The second is a status that moves from one active code to another with no idle clock between them. Neither happens in orderly bus traffic. The vector table creates both on purpose: a fetch cycle whose code changes to memory read without an idle gap, and an interrupt-acknowledge cycle ended by raising float_i while the status still shows the active code. Directed steps then apply reset partway through a cycle and hold all ones across reset release.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int STATUS_W = 3;
  localparam int CMD_W    = 6;

  localparam logic [STATUS_W-1:0] ST_INTA    = 3'b000;
  localparam logic [STATUS_W-1:0] ST_IO_RD   = 3'b001;
  localparam logic [STATUS_W-1:0] ST_IO_WR   = 3'b010;
  localparam logic [STATUS_W-1:0] ST_HALT    = 3'b011;
  localparam logic [STATUS_W-1:0] ST_FETCH   = 3'b100;
  localparam logic [STATUS_W-1:0] ST_MEM_RD  = 3'b101;
  localparam logic [STATUS_W-1:0] ST_MEM_WR  = 3'b110;
  localparam logic [STATUS_W-1:0] ST_PASSIVE = 3'b111;

  // status code that drives each command strobe bit
  function automatic logic [STATUS_W-1:0] cmd_code(input int idx);
    case (idx)
      0:       return ST_INTA;
      1:       return ST_IO_RD;
      2:       return ST_IO_WR;
      3:       return ST_FETCH;
      4:       return ST_MEM_RD;
      default: return ST_MEM_WR;
    endcase
  endfunction
endpackage

// File: rtl/bsd_frame.sv
module bsd_frame
  import bsd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                float_i,
  output logic                start_o,
  output logic                end_o,
  output logic                busy_o,
  output logic                hold_en_o,
  output logic [STATUS_W-1:0] code_o
);
  logic [STATUS_W-1:0] eff, st_q, code_q;
  logic start_q, end_q, busy_q;
  logic eff_pas, st_pas, begin_cyc;

  // floated bus reads as idle
  assign eff       = float_i ? ST_PASSIVE : status_i;
  assign eff_pas   = (eff == ST_PASSIVE);
  assign st_pas    = (st_q == ST_PASSIVE);
  assign begin_cyc = st_pas && !eff_pas;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PASSIVE;
      code_q  <= ST_PASSIVE;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      st_q    <= eff;
      start_q <= begin_cyc;
      end_q   <= busy_q && eff_pas;
      if (busy_q && eff_pas)  busy_q <= 1'b0;
      else if (begin_cyc)     busy_q <= 1'b1;
      if (!busy_q && begin_cyc) code_q <= eff;
    end
  end

  assign start_o   = start_q;
  assign end_o     = end_q;
  assign busy_o    = busy_q;
  assign hold_en_o = busy_q && !eff_pas;
  assign code_o    = code_q;

  p_start_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  p_busy_with_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> busy_q);
  p_end_clears_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |-> !busy_q && $past(busy_q));
endmodule

// File: rtl/bsd_cmd.sv
module bsd_cmd
  import bsd_pkg::*;
#(
  parameter int N_CMD = CMD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [STATUS_W-1:0] code_i,
  output logic [N_CMD-1:0]    cmd_o,
  output logic                halt_o
);
  logic [N_CMD-1:0] cmd_d, cmd_q;
  logic halt_q;

  for (genvar i = 0; i < N_CMD; i++) begin : g_dec
    assign cmd_d[i] = en_i && (code_i == cmd_code(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      halt_q <= en_i && (code_i == ST_HALT);
    end
  end

  assign cmd_o  = cmd_q;
  assign halt_o = halt_q;

  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_q, halt_q}));
  p_strobe_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_q) && en_i |=> $stable(cmd_q));
  p_halt_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && en_i |=> halt_q);
endmodule

// File: rtl/bus_status_decoder.sv
module bus_status_decoder
  import bsd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                float_i,
  output logic                cyc_start_o,
  output logic                cyc_end_o,
  output logic                busy_o,
  output logic [CMD_W-1:0]    cmd_o,
  output logic                halt_o
);
  logic                hold_en;
  logic [STATUS_W-1:0] code;

  bsd_frame i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .status_i  (status_i),
    .float_i   (float_i),
    .start_o   (cyc_start_o),
    .end_o     (cyc_end_o),
    .busy_o    (busy_o),
    .hold_en_o (hold_en),
    .code_o    (code)
  );

  bsd_cmd #(.N_CMD(CMD_W)) i_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (hold_en),
    .code_i (code),
    .cmd_o  (cmd_o),
    .halt_o (halt_o)
  );

  p_idle_no_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cmd_o == '0) && !halt_o);
  p_float_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_i |=> !cyc_start_o && !(|cmd_o) && !halt_o);
  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !cyc_start_o && !cyc_end_o);
endmodule

// File: tb/test_bus_status_decoder.sv
module test_bus_status_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 30;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] status_i = 3'b111;
  logic       float_i = 1'b0;
  logic       cyc_start_o, cyc_end_o, busy_o, halt_o;
  logic [5:0] cmd_o;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_status_decoder i_bus_status_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status_i), .float_i(float_i),
    .cyc_start_o(cyc_start_o), .cyc_end_o(cyc_end_o), .busy_o(busy_o),
    .cmd_o(cmd_o), .halt_o(halt_o)
  );

  // {float, status, exp start, exp end, exp busy, exp cmd[5:0], exp halt}
  localparam logic [13:0] VEC [NVEC] = '{
    14'b0_111_0_0_0_000000_0, // idle
    14'b0_101_1_0_1_000000_0, // R2 mem read start
    14'b0_101_0_0_1_010000_0, // R5 mem read strobe
    14'b0_101_0_0_1_010000_0, // R3 busy held
    14'b0_111_0_1_0_000000_0, // R4 end
    14'b0_111_0_0_0_000000_0,
    14'b0_010_1_0_1_000000_0, // io write start
    14'b0_010_0_0_1_000100_0, // R5 io write
    14'b0_111_0_1_0_000000_0,
    14'b0_011_1_0_1_000000_0, // halt start
    14'b0_011_0_0_1_000000_1, // R6 halt flag only
    14'b0_111_0_1_0_000000_0,
    14'b0_100_1_0_1_000000_0, // fetch start
    14'b0_100_0_0_1_001000_0, // R5 fetch
    14'b0_101_0_0_1_001000_0, // R9 code change mid-cycle
    14'b0_111_0_1_0_000000_0,
    14'b1_000_0_0_0_000000_0, // R7 floated, ignored
    14'b1_000_0_0_0_000000_0,
    14'b0_000_1_0_1_000000_0, // inta start
    14'b0_000_0_0_1_000001_0, // R5 inta
    14'b1_000_0_1_0_000000_0, // R7 float ends cycle
    14'b0_111_0_0_0_000000_0,
    14'b0_001_1_0_1_000000_0, // io read start
    14'b0_001_0_0_1_000010_0, // R5 io read
    14'b0_111_0_1_0_000000_0,
    14'b0_110_1_0_1_000000_0, // mem write start
    14'b0_110_0_0_1_100000_0, // R5 mem write
    14'b0_111_0_1_0_000000_0,
    14'b0_101_1_0_1_000000_0, // one-clock cycle
    14'b0_111_0_1_0_000000_0  // R4 end without strobe
  };

  task automatic check(input logic [9:0] exp, input string tag);
    logic [9:0] got;
    got = {cyc_start_o, cyc_end_o, busy_o, cmd_o, halt_o};
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1 reset state, R8 all-ones across release
    #(CLK_PERIOD * 2);
    check(10'b0, "R1 reset state");
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_i); #1;
      check(10'b0, "R8 all ones after reset");
    end

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      float_i  = VEC[i][13];
      status_i = VEC[i][12:10];
      @(posedge clk_i); #1;
      check(VEC[i][9:0], $sformatf("R2/R3/R4/R5/R6/R7/R9 row %0d", i));
    end

    // R1 reset in the middle of a cycle
    @(negedge clk_i);
    status_i = 3'b110;
    @(posedge clk_i); #1;
    @(posedge clk_i); #1;
    check(10'b0_0_1_100000_0, "R5 mem write before reset");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(10'b0, "R1 reset mid-cycle");
    status_i = 3'b111;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(10'b0, "R8 no start after reset release");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule